// File: doc/BRIEF.md
# Coprocessor External Bus Hold Arbiter

This block decides, cycle by cycle, which of three masters owns a shared external memory bus: the host CPU core (the default owner), an external bus master that asks through a hold pin, and an on-chip coprocessor that asks through an internal hold request and is answered by a hold acknowledge. The acknowledge is the coprocessor grant output. The external master always beats the coprocessor. The coprocessor keeps the bus until its current transaction ends, and then the bus returns to the core for a fixed slot (one cycle by default) so the core can fit in one access of its own.

A software-written hold flag can block the coprocessor. While the flag is set, the coprocessor gets no new grant. A coprocessor that asks in that time waits in a parked state, which the block shows on an output, until software writes the flag back to zero. A transaction that is already running when the flag is set runs to its end. The block does not control memory timing, and it does not order core and coprocessor traffic.

Top module: `hold_arbiter`

## Requirements
- R1: After reset, gnt_core is 1, gnt_cop and gnt_ext are 0, and hold_flag equals the parameter FLAG_RST (default 0).
- R2: Exactly one of gnt_core, gnt_cop and gnt_ext is 1 in every cycle.
- R3: When the core owns the bus outside a core slot, ext_hold_req is 0, hold_flag is 0 and cop_hold_req is 1 at a rising edge, gnt_cop is 1 after that edge.
- R4: When the core or the external master owns the bus outside a core slot and ext_hold_req is 1 at a rising edge, gnt_ext is 1 after that edge, whatever cop_hold_req is.
- R5: A rising edge that samples cop_xact_done = 1 while gnt_cop is 1 ends the grant. gnt_core is then 1 for exactly CORE_SLOT_CYC cycles, whatever the requests are, and arbitration resumes at the edge that ends the slot.
- R6: gnt_ext stays 1 for as long as ext_hold_req stays 1.
- R7: While hold_flag is 1, gnt_cop does not become 1, and cop_parked is 1 whenever cop_hold_req is 1 and gnt_cop is 0.
- R8: Once granted, gnt_cop stays 1 until cop_xact_done is sampled at 1. Neither ext_hold_req nor setting hold_flag cuts it short.
- R9: hold_flag takes the value of hold_flag_val at the edge where hold_flag_wr is 1. Arbitration at that edge still uses the old flag value, so a parked coprocessor is granted at the next decision edge after the flag reads 0.
- R10: cop_xact_done sampled while gnt_cop is 0 has no effect on the grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_hold_req | input | 1 | Hold request from the external bus master |
| cop_hold_req | input | 1 | Internal hold request from the coprocessor |
| cop_xact_done | input | 1 | Coprocessor transaction ends this cycle |
| hold_flag_wr | input | 1 | Write strobe for the software hold flag |
| hold_flag_val | input | 1 | Value written to the hold flag |
| gnt_core | output | 1 | Bus owned by the CPU core |
| gnt_cop | output | 1 | Hold acknowledge: bus owned by the coprocessor |
| gnt_ext | output | 1 | Bus owned by the external master |
| hold_flag | output | 1 | Current software hold flag |
| cop_parked | output | 1 | Coprocessor waiting because the flag blocks it |

## Verification
On every cycle the assertions check that exactly one grant is active, that a coprocessor grant survives until its transaction ends, and that a core slot always follows. They also check that the slot holds its full length, that the external master keeps the bus while it asks, that it wins any free decision, and that a set flag keeps the coprocessor out. Only the bench scenarios show the latency of a fresh coprocessor grant, the one-edge lag of a flag write, the parked indication, and that a stray transaction-end pulse does nothing. A long pseudo-random sweep compared against a cycle model covers the mixed input orders.

// File: rtl/hold_arb_pkg.sv
package hold_arb_pkg;

  typedef enum logic [1:0] {
    OWN_CORE = 2'd0,
    OWN_COP  = 2'd1,
    OWN_EXT  = 2'd2,
    OWN_SLOT = 2'd3
  } owner_e;

  // Priority decision: external master, then unblocked coprocessor, else core.
  function automatic owner_e pick_owner(input logic ext_req,
                                        input logic cop_req,
                                        input logic blocked);
    if (ext_req)
      return OWN_EXT;
    else if (cop_req && !blocked)
      return OWN_COP;
    else
      return OWN_CORE;
  endfunction

  function automatic logic owner_is_core(input owner_e own);
    return (own == OWN_CORE) || (own == OWN_SLOT);
  endfunction

endpackage

// File: rtl/hold_flag_reg.sv
module hold_flag_reg #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  output logic flag_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= RST_VAL;
    else if (wr_en)
      flag_q <= wr_val;
  end

endmodule

// File: rtl/core_slot_timer.sv
module core_slot_timer #(
  parameter int SLOT_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);

  localparam int CW = (SLOT_CYC < 2) ? 1 : $clog2(SLOT_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(SLOT_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/owner_fsm.sv
module owner_fsm
  import hold_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ext_req,
  input  logic   cop_req,
  input  logic   cop_done,
  input  logic   blocked,
  input  logic   slot_expired,
  output logic   slot_load,
  output owner_e owner
);

  owner_e owner_d;

  assign slot_load = (owner == OWN_COP) && cop_done;

  always_comb begin
    owner_d = owner;
    unique case (owner)
      OWN_COP:  owner_d = cop_done ? OWN_SLOT : OWN_COP;
      OWN_SLOT: owner_d = slot_expired ? pick_owner(ext_req, cop_req, blocked)
                                       : OWN_SLOT;
      default:  owner_d = pick_owner(ext_req, cop_req, blocked);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      owner <= OWN_CORE;
    else
      owner <= owner_d;
  end

endmodule

// File: rtl/hold_arbiter.sv
module hold_arbiter
  import hold_arb_pkg::*;
#(
  parameter int CORE_SLOT_CYC = 1,
  parameter bit FLAG_RST      = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_hold_req,
  input  logic cop_hold_req,
  input  logic cop_xact_done,
  input  logic hold_flag_wr,
  input  logic hold_flag_val,
  output logic gnt_core,
  output logic gnt_cop,
  output logic gnt_ext,
  output logic hold_flag,
  output logic cop_parked
);

  owner_e owner;
  logic   slot_load;
  logic   slot_expired;
  logic   in_slot;

  hold_flag_reg #(.RST_VAL(FLAG_RST)) u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (hold_flag_wr),
    .wr_val (hold_flag_val),
    .flag_q (hold_flag)
  );

  core_slot_timer #(.SLOT_CYC(CORE_SLOT_CYC)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (slot_load),
    .expired (slot_expired)
  );

  owner_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .ext_req      (ext_hold_req),
    .cop_req      (cop_hold_req),
    .cop_done     (cop_xact_done),
    .blocked      (hold_flag),
    .slot_expired (slot_expired),
    .slot_load    (slot_load),
    .owner        (owner)
  );

  assign in_slot    = (owner == OWN_SLOT);
  assign gnt_core   = owner_is_core(owner);
  assign gnt_cop    = (owner == OWN_COP);
  assign gnt_ext    = (owner == OWN_EXT);
  assign cop_parked = cop_hold_req && hold_flag && !gnt_cop;

endmodule

// File: rtl/hold_arbiter_chk.sv
module hold_arbiter_chk
  import hold_arb_pkg::*;
(
  input logic   clk,
  input logic   rst_n,
  input logic   ext_hold_req,
  input logic   cop_xact_done,
  input logic   gnt_core,
  input logic   gnt_cop,
  input logic   gnt_ext,
  input logic   hold_flag,
  input logic   in_slot,
  input logic   slot_expired
);

  assert_one_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({gnt_core, gnt_cop, gnt_ext}) == 1);

  assert_txn_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_cop && !cop_xact_done |=> gnt_cop);

  assert_slot_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_cop && cop_xact_done |=> gnt_core && in_slot);

  assert_slot_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_slot && !slot_expired |=> in_slot && gnt_core);

  assert_ext_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_ext && ext_hold_req |=> gnt_ext);

  assert_ext_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hold_req && !gnt_cop && !in_slot |=> gnt_ext);

  assert_flag_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_flag && !gnt_cop |=> !gnt_cop);

endmodule

bind hold_arbiter hold_arbiter_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ext_hold_req  (ext_hold_req),
  .cop_xact_done (cop_xact_done),
  .gnt_core      (gnt_core),
  .gnt_cop       (gnt_cop),
  .gnt_ext       (gnt_ext),
  .hold_flag     (hold_flag),
  .in_slot       (in_slot),
  .slot_expired  (slot_expired)
);

// File: tb/sim_hold_arbiter.sv
module sim_hold_arbiter;

  localparam int SLOT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_req = 1'b0, cop_req = 1'b0, cop_done = 1'b0;
  logic fwr = 1'b0, fval = 1'b0;
  logic g_core, g_cop, g_ext, flag, parked;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // model: 0 core, 1 cop, 2 ext, 3 core slot
  int m_own = 0;
  int m_cnt = 0;
  bit m_flag = 1'b0;

  always #10 clk = ~clk;

  hold_arbiter #(.CORE_SLOT_CYC(SLOT), .FLAG_RST(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_hold_req(ext_req), .cop_hold_req(cop_req),
    .cop_xact_done(cop_done), .hold_flag_wr(fwr), .hold_flag_val(fval),
    .gnt_core(g_core), .gnt_cop(g_cop), .gnt_ext(g_ext),
    .hold_flag(flag), .cop_parked(parked)
  );

  function automatic int decide(bit e, bit c, bit blk);
    if (e) return 2;
    if (c && !blk) return 1;
    return 0;
  endfunction

  task automatic step();
    case (m_own)
      1: if (cop_done) begin m_own = 3; m_cnt = SLOT - 1; end
      3: if (m_cnt == 0) m_own = decide(ext_req, cop_req, m_flag);
         else m_cnt = m_cnt - 1;
      default: m_own = decide(ext_req, cop_req, m_flag);
    endcase
    if (fwr) m_flag = fval;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req);
    bit ec, ep, ee, epk;
    ec = (m_own == 0) || (m_own == 3);
    ep = (m_own == 1);
    ee = (m_own == 2);
    epk = cop_req && m_flag && !ep;
    checks++;
    if ({g_core, g_cop, g_ext, flag, parked} !== {ec, ep, ee, m_flag, epk}) begin
      errors++;
      $display("FAIL %s: core/cop/ext/flag/parked actual %b%b%b%b%b expected %b%b%b%b%b",
               req, g_core, g_cop, g_ext, flag, parked, ec, ep, ee, m_flag, epk);
    end
  endtask

  task automatic run(string req, int n);
    for (int i = 0; i < n; i++) begin
      step();
      chk(req);
    end
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    chk("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1");

    cop_req = 1'b1;
    run("R3", 1);
    ext_req = 1'b1;
    run("R8", 3);
    cop_done = 1'b1;
    run("R5", 1);
    cop_done = 1'b0;
    run("R5", SLOT);
    run("R6", 3);
    ext_req = 1'b0;
    run("R3", 1);
    fwr = 1'b1; fval = 1'b1;
    run("R8", 1);
    fwr = 1'b0;
    run("R8", 2);
    cop_done = 1'b1;
    run("R5", 1);
    cop_done = 1'b0;
    run("R7", SLOT + 4);
    fwr = 1'b1; fval = 1'b0;
    run("R9", 1);
    fwr = 1'b0;
    run("R9", 1);
    cop_done = 1'b1;
    run("R5", 1);
    cop_req = 1'b0;
    run("R10", SLOT + 3);
    cop_done = 1'b0;
    run("R10", 1);
    ext_req = 1'b1; cop_req = 1'b1;
    run("R4", 2);
    ext_req = 1'b0; cop_req = 1'b0;
    run("R2", 2);

    // pseudo-random sweep against the cycle model
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ext_req  = (lfsr[2:0] == 3'd0);
        cop_req  = lfsr[4] | lfsr[5];
        cop_done = lfsr[7] & lfsr[8];
        fwr      = (lfsr[11:9] == 3'd7);
        fval     = lfsr[12];
        step();
        chk("R2 sweep");
      end
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

endmodule